// File: doc/BRIEF.md
# Clock-Enable, Power-Mode and Reset Sequencer

This block gives a small microcontroller its time base. It divides the oscillator clock by two and steps through a machine cycle of six states, each with two phases. From that count it produces one clock enable for the processor and one for the peripherals. It also owns the power-control register. The idle bit (bit 0) of that register gates only the processor enable. The power-down bit (bit 1) stops every enable and tells the oscillator to halt. A pending interrupt brings the processor out of idle, but only a reset brings the chip out of power-down.

The external reset pin is active high. It passes through a synchronizer and an agreement filter. The result is then sampled once per machine cycle, at the second phase of the fifth state (state 4, phase 1). `sfr_rst` asserts after `QUAL_CYC` consecutive high samples. It drops at the end of the first machine cycle that follows a low sample. While `sfr_rst` is high, the register file loads its default values. The power-control register itself clears, except bit 4, which keeps its value. An asynchronous power-on reset sets bit 4 and also asserts `sfr_rst`.

Top module: `pwr_rst_ctrl`

## Requirements
- R1: While `rst_n` is low: `sfr_rst` = 1, `pcon_q` = 8'h10, `m_state` = 0 and `m_phase` = 0.
- R2: While `osc_en` is high, `m_phase` toggles on every clock. `m_state` advances 0 to 5 on each clock that ends a phase-1 slot, then wraps to 0. `per_ce` is high exactly in the phase-1 slots (once every two clocks).
- R3: When bit 0 (idle) of `pcon_q` is clear and power-down is off, `cpu_ce` equals `per_ce`. When the idle bit is set, `cpu_ce` stays low while `per_ce` keeps pulsing.
- R4: If `irq_pend` is high during idle, with no write and no reset in that cycle, the idle bit clears at that clock edge. `cpu_ce` returns on the next phase-1 slot.
- R5: While bit 1 (power-down) is set and the filtered pin is low, `osc_en`, `per_ce` and `cpu_ce` are low and `m_state`/`m_phase` hold their values. `irq_pend` has no effect on `pcon_q`.
- R6: The filtered pin is sampled only at state 4, phase 1. `sfr_rst` rises at such a sample after `QUAL_CYC` (default 2) consecutive high samples. A high level that covers fewer samples causes no reset.
- R7: A pin pulse shorter than `FILT_LEN` (default 3) clocks has no effect. It causes no reset and, in power-down, does not restart the oscillator.
- R8: Outside reset, a write with `pcon_wr` loads all 8 bits at the next edge. While `sfr_rst` is high, `pcon_q` is cleared except bit 4, which keeps its value, and writes are ignored.
- R9: After a low sample, `sfr_rst` falls at the edge that leaves state 5, phase 1. After that edge `m_state` = 0 and `m_phase` = 0.
- R10: In power-down, a pin held high restarts the oscillator (`osc_en` = 1) once it clears the filter. The qualified reset that follows clears the power-down bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| rst_pin | input | 1 | External reset pin, active high, asynchronous |
| irq_pend | input | 1 | An enabled interrupt is pending |
| pcon_wr | input | 1 | Write strobe for the power-control register |
| pcon_wdata | input | 8 | Write data for the power-control register |
| pcon_q | output | 8 | Power-control register contents |
| cpu_ce | output | 1 | Processor clock enable |
| per_ce | output | 1 | Peripheral and interrupt-logic clock enable |
| osc_en | output | 1 | Oscillator run request |
| sfr_rst | output | 1 | Synchronous reset that loads register defaults |
| m_state | output | 3 | Current machine-cycle state, 0 to 5 |
| m_phase | output | 1 | Current phase within the state |

## Verification
The properties assume that `irq_pend` comes from logic clocked by `clk`. They also assume that software does not write the register in the same cycle as the interrupt that wakes idle, so the idle-exit property skips cycles that contain a write. The bench keeps to these conditions: it drives every input at the falling edge, and its random writes mask out the idle and power-down bits. It enters idle and power-down only through directed steps, with the interrupt pulse on its own clock. Reset-pin pulses are shaped so that each one is either clearly below the filter length or held for long enough to cover the two qualifying samples.

// File: rtl/pwr_rst_ctrl.sv
module pwr_rst_ctrl #(
  parameter int FILT_LEN = 3,
  parameter int QUAL_CYC = 2,
  parameter int IDLE_BIT = 0,
  parameter int PD_BIT   = 1,
  parameter int KEEP_BIT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rst_pin,
  input  logic       irq_pend,
  input  logic       pcon_wr,
  input  logic [7:0] pcon_wdata,
  output logic [7:0] pcon_q,
  output logic       cpu_ce,
  output logic       per_ce,
  output logic       osc_en,
  output logic       sfr_rst,
  output logic [2:0] m_state,
  output logic       m_phase
);
  localparam int            QW        = $clog2(QUAL_CYC + 1);
  localparam logic [QW-1:0] QMAX      = QW'(QUAL_CYC);
  localparam logic [QW-1:0] QLAST     = QW'(QUAL_CYC - 1);
  localparam logic [7:0]    KEEP_MASK = 8'(1) << KEEP_BIT;
  localparam logic [2:0]    LAST_ST   = 3'd5;
  localparam logic [2:0]    SAMP_ST   = 3'd4;

  logic [1:0]          sync;
  logic [FILT_LEN-1:0] shf;
  logic                pin_f;
  logic [2:0]          st;
  logic                ph;
  logic [QW-1:0]       qcnt;
  logic                hold, rel;
  logic [7:0]          pcon;
  logic                pd, idle, p2, samp, bound;

  assign pd     = pcon[PD_BIT];
  assign idle   = pcon[IDLE_BIT];
  assign osc_en = !pd || pin_f;
  assign p2     = osc_en && ph;
  assign samp   = p2 && (st == SAMP_ST);
  assign bound  = p2 && (st == LAST_ST);
  assign per_ce = p2 && !pd;
  assign cpu_ce = per_ce && !idle;

  assign pcon_q  = pcon;
  assign sfr_rst = hold;
  assign m_state = st;
  assign m_phase = ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync  <= '0;
      shf   <= '0;
      pin_f <= 1'b0;
    end else begin
      sync <= {sync[0], rst_pin};
      shf  <= {shf[FILT_LEN-2:0], sync[1]};
      if (&shf)       pin_f <= 1'b1;
      else if (~|shf) pin_f <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= '0;
      ph <= 1'b0;
    end else if (osc_en) begin
      ph <= ~ph;
      if (ph) st <= (st == LAST_ST) ? 3'd0 : st + 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold <= 1'b1;
      rel  <= 1'b0;
      qcnt <= '0;
    end else begin
      if (samp) begin
        if (pin_f) begin
          rel <= 1'b0;
          if (qcnt < QMAX)   qcnt <= qcnt + QW'(1);
          if (qcnt >= QLAST) hold <= 1'b1;
        end else begin
          qcnt <= '0;
          if (hold) rel <= 1'b1;
        end
      end
      if (bound && rel) begin
        hold <= 1'b0;
        rel  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      pcon <= KEEP_MASK;
    else if (hold)                   pcon <= pcon & KEEP_MASK;
    else if (pcon_wr)                pcon <= pcon_wdata;
    else if (irq_pend && idle && !pd) pcon[IDLE_BIT] <= 1'b0;
  end
endmodule

// File: rtl/pwr_rst_ctrl_sva.sv
module pwr_rst_ctrl_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       irq_pend,
  input logic       pcon_wr,
  input logic [7:0] pcon_q,
  input logic       cpu_ce,
  input logic       per_ce,
  input logic       osc_en,
  input logic       sfr_rst,
  input logic [2:0] m_state,
  input logic       m_phase
);
  p_phase_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    osc_en |=> (m_phase != $past(m_phase)));

  p_state_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    m_state <= 3'd5);

  p_ce_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    per_ce |-> m_phase);

  p_idle_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pcon_q[0] |-> !cpu_ce);

  p_idle_wake_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pcon_q[0] && irq_pend && !pcon_wr && !sfr_rst && !pcon_q[1]) |=> !pcon_q[0]);

  p_pd_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pcon_q[1] |-> (!per_ce && !cpu_ce));

  p_pd_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pcon_q[1] && !osc_en) |=> ($stable(m_state) && $stable(m_phase)));

  p_rst_at_sample_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sfr_rst) |-> (m_state == 3'd5 && !m_phase));

  p_keep_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_rst |=> (pcon_q[4] == $past(pcon_q[4]) && (pcon_q & 8'hEF) == 8'h00));

  p_rel_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sfr_rst) |-> (m_state == 3'd0 && !m_phase));
endmodule

bind pwr_rst_ctrl pwr_rst_ctrl_sva u_sva (
  .clk(clk), .rst_n(rst_n), .irq_pend(irq_pend), .pcon_wr(pcon_wr),
  .pcon_q(pcon_q), .cpu_ce(cpu_ce), .per_ce(per_ce), .osc_en(osc_en),
  .sfr_rst(sfr_rst), .m_state(m_state), .m_phase(m_phase)
);

// File: tb/pwr_rst_ctrl_tb.sv
module pwr_rst_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rst_pin = 1'b0;
  logic       irq_pend = 1'b0;
  logic       pcon_wr = 1'b0;
  logic [7:0] pcon_wdata = 8'h00;
  logic [7:0] pcon_q;
  logic       cpu_ce, per_ce, osc_en, sfr_rst, m_phase;
  logic [2:0] m_state;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #4 clk = ~clk;

  pwr_rst_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .rst_pin(rst_pin), .irq_pend(irq_pend),
    .pcon_wr(pcon_wr), .pcon_wdata(pcon_wdata), .pcon_q(pcon_q),
    .cpu_ce(cpu_ce), .per_ce(per_ce), .osc_en(osc_en), .sfr_rst(sfr_rst),
    .m_state(m_state), .m_phase(m_phase)
  );

  function automatic logic [3:0] next_pos(input logic [3:0] p);
    if (!p[0]) return {p[3:1], 1'b1};
    return {(p[3:1] == 3'd5) ? 3'd0 : p[3:1] + 3'd1, 1'b0};
  endfunction

  function automatic logic [7:0] after_reset(input logic [7:0] v);
    return v & 8'h10;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    pcon_wr = 1'b1; pcon_wdata = d;
    step(1);
    pcon_wr = 1'b0;
  endtask

  task automatic wait_rst(input logic lvl, input int lim, output int n);
    n = 0;
    while (sfr_rst !== lvl && n < lim) begin step(1); n++; end
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    int n;
    logic [3:0] pos;
    logic [7:0] d;
    void'($urandom(32'd2024));

    step(3);
    chk("R1 pcon", pcon_q, 8'h10);
    chk("R1 sfr_rst", sfr_rst, 1);
    chk("R1 state", {m_state, m_phase}, 4'h0);

    rst_n = 1'b1;
    wait_rst(1'b0, 60, n);
    chk("R9 por release", sfr_rst, 0);
    chk("R9 release boundary", {m_state, m_phase}, 4'h0);

    pos = {m_state, m_phase};
    for (int i = 0; i < 60; i++) begin
      step(1);
      pos = next_pos(pos);
      chk("R2 sequence", {m_state, m_phase}, pos);
      chk("R2 per_ce slot", per_ce, m_phase);
      chk("R3 cpu_ce follows", cpu_ce, per_ce);
    end

    for (int i = 0; i < 40; i++) begin
      d = 8'($urandom) & 8'hFC;
      irq_pend = 1'($urandom);
      wr(d);
      chk("R8 write", pcon_q, d);
      step(1);
      irq_pend = 1'b0;
      chk("R8 hold value", pcon_q, d);
    end

    for (int r = 0; r < 6; r++) begin
      wr(8'h01);
      chk("R3 idle set", pcon_q, 8'h01);
      for (int k = 0; k < 4 + int'($urandom % 27); k++) begin
        chk("R3 cpu gated", cpu_ce, 0);
        chk("R3 per runs", per_ce, m_phase);
        step(1);
      end
      irq_pend = 1'b1;
      step(1);
      irq_pend = 1'b0;
      chk("R4 idle cleared", pcon_q, 8'h00);
      if (!m_phase) step(1);
      chk("R4 cpu_ce back", cpu_ce, 1);
    end

    for (int g = 1; g < 3; g++) begin
      rst_pin = 1'b1; step(g); rst_pin = 1'b0;
      for (int k = 0; k < 30; k++) begin
        step(1);
        if (sfr_rst) break;
      end
      chk("R7 glitch ignored", sfr_rst, 0);
    end

    rst_pin = 1'b1; step(8); rst_pin = 1'b0;
    n = 0;
    for (int k = 0; k < 40; k++) begin step(1); if (sfr_rst) n++; end
    chk("R6 single sample no reset", n, 0);

    wr(8'hEC);
    rst_pin = 1'b1;
    wait_rst(1'b1, 60, n);
    chk("R6 qualified", sfr_rst, 1);
    chk("R6 after S5P2", {m_state, m_phase}, {3'd5, 1'b0});
    chk("R6 timing", (n >= 19 && n <= 30), 1);
    step(1);
    chk("R8 cleared", pcon_q, after_reset(8'hEC));
    wr(8'hAA);
    chk("R8 write ignored", pcon_q, 8'h00);
    rst_pin = 1'b0;
    wait_rst(1'b0, 60, n);
    chk("R9 release", sfr_rst, 0);
    chk("R9 boundary", {m_state, m_phase}, 4'h0);
    chk("R9 timing", (n >= 9 && n <= 20), 1);

    wr(8'h1C);
    rst_pin = 1'b1; step(40); rst_pin = 1'b0;
    wait_rst(1'b0, 60, n);
    chk("R8 bit4 kept", pcon_q, after_reset(8'h1C));

    wr(8'h12);
    pos = {m_state, m_phase};
    for (int k = 0; k < 30; k++) begin
      if (k == 10) irq_pend = 1'b1;
      if (k == 11) irq_pend = 1'b0;
      chk("R5 osc off", osc_en, 0);
      chk("R5 enables off", {per_ce, cpu_ce}, 2'b00);
      chk("R5 frozen", {m_state, m_phase}, pos);
      step(1);
    end
    chk("R5 irq no effect", pcon_q, 8'h12);
    rst_pin = 1'b1; step(2); rst_pin = 1'b0;
    for (int k = 0; k < 20; k++) begin
      chk("R7 pd glitch", osc_en, 0);
      step(1);
    end
    rst_pin = 1'b1;
    n = 0;
    while (!osc_en && n < 20) begin step(1); n++; end
    chk("R10 osc restart", osc_en, 1);
    wait_rst(1'b1, 60, n);
    chk("R10 reset", sfr_rst, 1);
    step(1);
    chk("R10 pd cleared", pcon_q, 8'h10);
    rst_pin = 1'b0;
    wait_rst(1'b0, 60, n);
    pos = {m_state, m_phase};
    step(1);
    chk("R10 running", {m_state, m_phase}, next_pos(pos));

    done = 1'b1;
    finish_run();
  end
endmodule